// File: doc/BRIEF.md
# Global Control Group Filter

This block judges a received global-control request on behalf of a fieldbus slave. The upstream receiver presents the decoded frame fields for one cycle, marked by a valid strobe. The fields are the source and destination service access point numbers, the net-data length, a command byte and a group-select byte. The block also reads the slave's current protocol state, a flag that turns reserved-bit policing off, and the slave's 8-bit group membership register.

One clock after the strobe, the block either:

- raises an "addressed" pulse together with the decoded command pulses (clear, freeze, unfreeze, sync, unsync), or
- raises a leave-master pulse when policing is on and reserved command bits are set, or
- stays silent.

The control path is a small state machine whose state register holds the verdict for the cycle after the strobe. The states are:

- IDLE: no frame to report.
- ADDR: the frame addresses this slave.
- LEAVE: reserved bits were found while policing is on.
- DROP: the frame qualified but is not for this slave's groups.

Every state is re-entered from the next cycle's verdict. A strobe that qualifies moves to ADDR, LEAVE or DROP. A cycle without a qualifying strobe moves to IDLE. So each verdict lasts exactly one cycle.

Top module: `gc_group_filter`

## Requirements
- R1: A frame qualifies only when the source SAP is 62, the destination SAP is 58 and the net-data length is exactly 2; any other values produce no output pulse.
- R2: A frame qualifies only while `slave_state` equals the Data Exchange code 3'b100; in any other state it produces no output pulse.
- R3: A qualified, policed-clean frame addresses the slave when the bitwise AND of `grp_sel` and `grp_ident` is non-zero; if the AND is zero (and `grp_sel` is non-zero) no pulse of any kind is produced.
- R4: A `grp_sel` of zero addresses the slave whatever `grp_ident` holds, including zero.
- R5: With `resv_chk_off` = 0, a qualified frame whose command byte has bit 0, bit 1 or bit 7 set raises `leave_master` and no addressed or command pulse. This happens regardless of the group match.
- R6: With `resv_chk_off` = 1, reserved bits 0, 1 and 7 are ignored and the frame is handled as in R3/R4/R7.
- R7: When addressed, command bits map to pulses as follows: bit 2 to `clear_o`, bit 3 to `unfreeze_o`, bit 4 to `freeze_o`, bit 5 to `sync_o` and bit 6 to `unsync_o`. No command pulse occurs without `addressed_o`.
- R8: Freeze and unfreeze both set yield neither pulse; sync and unsync both set yield neither pulse. Clear is unaffected by either pair.
- R9: All outputs are one-cycle pulses, asserted in the cycle after the clock edge that samples `frm_valid`. Strobes on consecutive cycles give pulses on consecutive cycles.
- R10: While `rst_n` is low, and in the first cycle after it, all outputs are 0. Without a strobe, all outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle strobe marking valid frame fields |
| frm_ssap | input | 8 | Source service access point |
| frm_dsap | input | 8 | Destination service access point |
| frm_len | input | 8 | Net-data length in bytes |
| frm_cmd | input | 8 | Command byte |
| frm_grp | input | 8 | Group-select byte |
| slave_state | input | 3 | Current slave protocol state |
| resv_chk_off | input | 1 | 1 disables reserved-bit policing |
| grp_ident | input | 8 | Group membership register |
| addressed_o | output | 1 | Slave addressed pulse |
| clear_o | output | 1 | Clear-data command pulse |
| freeze_o | output | 1 | Freeze command pulse |
| unfreeze_o | output | 1 | Unfreeze command pulse |
| sync_o | output | 1 | Sync command pulse |
| unsync_o | output | 1 | Unsync command pulse |
| leave_master_o | output | 1 | Leave-master request pulse |

## Verification
Directed frames cover the following cases:

- each SAP and length mismatch taken alone, and each non-exchange state, which separates qualification from group logic;
- single-bit and disjoint group patterns, which separate the AND match from a plain non-zero test;
- a zero select against a zero membership register, which isolates the broadcast rule;
- each reserved bit with policing on and off, which tells policing apart from command decoding;
- the two conflicting command pairs, with and without clear.

Random frames, biased toward qualifying fields, mix all of these. Back-to-back strobes and quiet cycles show that the pulses last one cycle and land one clock late.

// File: rtl/gc_pkg.sv
package gc_pkg;

    // Verdict held for the cycle after a frame strobe
    typedef enum logic [1:0] {
        GC_IDLE  = 2'd0,
        GC_ADDR  = 2'd1,
        GC_LEAVE = 2'd2,
        GC_DROP  = 2'd3
    } gc_state_e;

    // Decoded command set
    typedef struct packed {
        logic clear;
        logic unfreeze;
        logic freeze;
        logic sync;
        logic unsync;
    } gc_cmd_t;

    // Command byte bit positions
    localparam int unsigned CMD_CLEAR_BIT    = 2;
    localparam int unsigned CMD_UNFREEZE_BIT = 3;
    localparam int unsigned CMD_FREEZE_BIT   = 4;
    localparam int unsigned CMD_SYNC_BIT     = 5;
    localparam int unsigned CMD_UNSYNC_BIT   = 6;
    localparam int unsigned CMD_W            = 8;

    // Bits 0, 1 and 7 are reserved
    localparam logic [CMD_W-1:0] CMD_RESV_MASK = 8'h83;

endpackage

// File: rtl/gc_frame_qual.sv
module gc_frame_qual #(
    parameter int unsigned SAP_W = 8,
    parameter int unsigned LEN_W = 8,
    parameter int unsigned ST_W  = 3,
    parameter logic [SAP_W-1:0] GC_SSAP = 8'd62,
    parameter logic [SAP_W-1:0] GC_DSAP = 8'd58,
    parameter logic [LEN_W-1:0] GC_LEN  = 8'd2,
    parameter logic [ST_W-1:0]  DX_CODE = 3'b100
) (
    input  logic             valid,
    input  logic [SAP_W-1:0] ssap,
    input  logic [SAP_W-1:0] dsap,
    input  logic [LEN_W-1:0] len,
    input  logic [ST_W-1:0]  state,
    output logic             take
);
    logic addr_ok;
    logic len_ok;
    logic st_ok;

    always_comb begin
        addr_ok = (ssap == GC_SSAP) && (dsap == GC_DSAP);
        len_ok  = (len == GC_LEN);
        st_ok   = (state == DX_CODE);
        take    = valid && addr_ok && len_ok && st_ok;
    end
endmodule

// File: rtl/gc_group_match.sv
module gc_group_match #(
    parameter int unsigned GRP_W = 8
) (
    input  logic [GRP_W-1:0] sel,
    input  logic [GRP_W-1:0] ident,
    output logic             hit
);
    logic [GRP_W-1:0] both;

    // One AND term per group
    for (genvar g = 0; g < GRP_W; g++) begin : g_grp
        assign both[g] = sel[g] & ident[g];
    end

    always_comb begin
        hit = (|both) || (sel == '0);
    end
endmodule

// File: rtl/gc_cmd_decode.sv
module gc_cmd_decode
    import gc_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    input  logic             chk_off,
    output logic             resv_bad,
    output gc_cmd_t          dec
);
    logic frz;
    logic ufrz;
    logic syn;
    logic usyn;

    always_comb begin
        resv_bad     = !chk_off && ((cmd & CMD_RESV_MASK) != '0);
        frz          = cmd[CMD_FREEZE_BIT];
        ufrz         = cmd[CMD_UNFREEZE_BIT];
        syn          = cmd[CMD_SYNC_BIT];
        usyn         = cmd[CMD_UNSYNC_BIT];
        dec.clear    = cmd[CMD_CLEAR_BIT];
        // Conflicting pairs cancel each other
        dec.freeze   = frz  && !ufrz;
        dec.unfreeze = ufrz && !frz;
        dec.sync     = syn  && !usyn;
        dec.unsync   = usyn && !syn;
    end
endmodule

// File: rtl/gc_group_filter.sv
module gc_group_filter
    import gc_pkg::*;
#(
    parameter int unsigned SAP_W = 8,
    parameter int unsigned LEN_W = 8,
    parameter int unsigned ST_W  = 3,
    parameter int unsigned GRP_W = 8,
    parameter logic [ST_W-1:0] DX_CODE = 3'b100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_valid,
    input  logic [SAP_W-1:0] frm_ssap,
    input  logic [SAP_W-1:0] frm_dsap,
    input  logic [LEN_W-1:0] frm_len,
    input  logic [CMD_W-1:0] frm_cmd,
    input  logic [GRP_W-1:0] frm_grp,
    input  logic [ST_W-1:0]  slave_state,
    input  logic             resv_chk_off,
    input  logic [GRP_W-1:0] grp_ident,
    output logic             addressed_o,
    output logic             clear_o,
    output logic             freeze_o,
    output logic             unfreeze_o,
    output logic             sync_o,
    output logic             unsync_o,
    output logic             leave_master_o
);
    localparam logic [SAP_W-1:0] GC_SSAP = SAP_W'(62);
    localparam logic [SAP_W-1:0] GC_DSAP = SAP_W'(58);
    localparam logic [LEN_W-1:0] GC_LEN  = LEN_W'(2);

    logic      take;
    logic      hit;
    logic      resv_bad;
    gc_cmd_t   dec;
    gc_cmd_t   cmd_q;
    gc_cmd_t   cmd_d;
    gc_state_e state_q;
    gc_state_e state_d;

    gc_frame_qual #(
        .SAP_W  (SAP_W),
        .LEN_W  (LEN_W),
        .ST_W   (ST_W),
        .GC_SSAP(GC_SSAP),
        .GC_DSAP(GC_DSAP),
        .GC_LEN (GC_LEN),
        .DX_CODE(DX_CODE)
    ) u_qual (
        .valid(frm_valid),
        .ssap (frm_ssap),
        .dsap (frm_dsap),
        .len  (frm_len),
        .state(slave_state),
        .take (take)
    );

    gc_group_match #(
        .GRP_W(GRP_W)
    ) u_match (
        .sel  (frm_grp),
        .ident(grp_ident),
        .hit  (hit)
    );

    gc_cmd_decode u_dec (
        .cmd     (frm_cmd),
        .chk_off (resv_chk_off),
        .resv_bad(resv_bad),
        .dec     (dec)
    );

    // Next-state and command capture
    always_comb begin
        state_d = GC_IDLE;
        cmd_d   = '0;
        if (take) begin
            if (resv_bad) begin
                state_d = GC_LEAVE;
            end else if (hit) begin
                state_d = GC_ADDR;
                cmd_d   = dec;
            end else begin
                state_d = GC_DROP;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GC_IDLE;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
        end
    end

    // Outputs from state
    always_comb begin
        addressed_o    = 1'b0;
        leave_master_o = 1'b0;
        clear_o        = 1'b0;
        freeze_o       = 1'b0;
        unfreeze_o     = 1'b0;
        sync_o         = 1'b0;
        unsync_o       = 1'b0;
        unique case (state_q)
            GC_IDLE: ;
            GC_DROP: ;
            GC_LEAVE: leave_master_o = 1'b1;
            GC_ADDR: begin
                addressed_o = 1'b1;
                clear_o     = cmd_q.clear;
                freeze_o    = cmd_q.freeze;
                unfreeze_o  = cmd_q.unfreeze;
                sync_o      = cmd_q.sync;
                unsync_o    = cmd_q.unsync;
            end
        endcase
    end

    AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (addressed_o || leave_master_o) |-> $past(frm_valid)); // R9
    AST_STATE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (addressed_o || leave_master_o) |-> ($past(slave_state) == DX_CODE)); // R2
    AST_LEAVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        leave_master_o |-> !(addressed_o || clear_o || freeze_o || sync_o)); // R5
    AST_LEAVE_POLICED: assert property (@(posedge clk) disable iff (!rst_n)
        leave_master_o |-> !$past(resv_chk_off)); // R6
    AST_CMD_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_o || freeze_o || unfreeze_o || sync_o || unsync_o) |-> addressed_o); // R7
    AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(freeze_o && unfreeze_o) && !(sync_o && unsync_o)); // R8
    AST_FRAME_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        addressed_o |-> ($past(frm_len) == GC_LEN && $past(frm_dsap) == GC_DSAP)); // R1
endmodule

// File: tb/gc_group_filter_tb.sv
module gc_group_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       frm_valid;
    logic [7:0] frm_ssap, frm_dsap, frm_len, frm_cmd, frm_grp, grp_ident;
    logic [2:0] slave_state;
    logic       resv_chk_off;
    logic       addressed_o, clear_o, freeze_o, unfreeze_o, sync_o, unsync_o, leave_master_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    gc_group_filter dut_i (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid),
        .frm_ssap(frm_ssap), .frm_dsap(frm_dsap), .frm_len(frm_len),
        .frm_cmd(frm_cmd), .frm_grp(frm_grp), .slave_state(slave_state),
        .resv_chk_off(resv_chk_off), .grp_ident(grp_ident),
        .addressed_o(addressed_o), .clear_o(clear_o), .freeze_o(freeze_o),
        .unfreeze_o(unfreeze_o), .sync_o(sync_o), .unsync_o(unsync_o),
        .leave_master_o(leave_master_o)
    );

    // Packing: {leave, addressed, clear, freeze, unfreeze, sync, unsync}
    function automatic logic [6:0] model(input logic [7:0] ss, ds, ln, cm, gs, gi,
                                         input logic [2:0] st, input logic off);
        logic [6:0] r;
        r = '0;
        if (ss == 8'd62 && ds == 8'd58 && ln == 8'd2 && st == 3'b100) begin
            if (!off && (cm[0] || cm[1] || cm[7])) begin
                r[6] = 1'b1;
            end else if (gs == 8'd0 || (gs & gi) != 8'd0) begin
                r[5] = 1'b1;
                r[4] = cm[2];
                r[3] = cm[4] && !cm[3];
                r[2] = cm[3] && !cm[4];
                r[1] = cm[5] && !cm[6];
                r[0] = cm[6] && !cm[5];
            end
        end
        return r;
    endfunction

    function automatic logic [6:0] outs();
        return {leave_master_o, addressed_o, clear_o, freeze_o, unfreeze_o, sync_o, unsync_o};
    endfunction

    task automatic check(input string req, input logic [6:0] exp);
        total++;
        if (outs() !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", req, outs(), exp);
        end
    endtask

    task automatic drive(input logic [7:0] ss, ds, ln, cm, gs, gi,
                         input logic [2:0] st, input logic off);
        frm_valid = 1'b1; frm_ssap = ss; frm_dsap = ds; frm_len = ln;
        frm_cmd = cm; frm_grp = gs; grp_ident = gi; slave_state = st; resv_chk_off = off;
    endtask

    // Drive at a falling edge, check after the next rising edge
    task automatic frame(input string req, input logic [7:0] ss, ds, ln, cm, gs, gi,
                         input logic [2:0] st, input logic off);
        @(negedge clk);
        drive(ss, ds, ln, cm, gs, gi, st, off);
        @(negedge clk);
        frm_valid = 1'b0;
        check(req, model(ss, ds, ln, cm, gs, gi, st, off));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog: got hang expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [7:0] cm;
        seed = $urandom(1234);
        rst_n = 1'b0;
        frm_valid = 1'b0;
        frm_ssap = 0; frm_dsap = 0; frm_len = 0; frm_cmd = 0; frm_grp = 0;
        grp_ident = 0; slave_state = 0; resv_chk_off = 0;
        repeat (3) @(negedge clk);
        check("R10 reset", 7'b0);
        @(negedge clk);
        drive(8'd62, 8'd58, 8'd2, 8'h3C, 8'h00, 8'h00, 3'b100, 1'b0);
        frm_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset", 7'b0);

        // R1 qualification
        frame("R1 good", 8'd62, 8'd58, 8'd2, 8'h04, 8'h01, 8'h01, 3'b100, 1'b0);
        frame("R1 ssap", 8'd61, 8'd58, 8'd2, 8'h04, 8'h01, 8'h01, 3'b100, 1'b0);
        frame("R1 dsap", 8'd62, 8'd57, 8'd2, 8'h04, 8'h01, 8'h01, 3'b100, 1'b0);
        frame("R1 len3", 8'd62, 8'd58, 8'd3, 8'h04, 8'h01, 8'h01, 3'b100, 1'b0);
        frame("R1 len1", 8'd62, 8'd58, 8'd1, 8'h04, 8'h01, 8'h01, 3'b100, 1'b0);
        // R2 state gating
        for (int s = 0; s < 8; s++)
            frame("R2 state", 8'd62, 8'd58, 8'd2, 8'h10, 8'h00, 8'h00, 3'(s), 1'b0);
        frame("R2 leave gated", 8'd62, 8'd58, 8'd2, 8'h80, 8'h00, 8'h00, 3'b011, 1'b0);
        // R3 group match
        frame("R3 hit", 8'd62, 8'd58, 8'd2, 8'h20, 8'h40, 8'hC0, 3'b100, 1'b0);
        frame("R3 miss", 8'd62, 8'd58, 8'd2, 8'h20, 8'h0F, 8'hF0, 3'b100, 1'b0);
        frame("R3 ident0", 8'd62, 8'd58, 8'd2, 8'h20, 8'h80, 8'h00, 3'b100, 1'b0);
        for (int b = 0; b < 8; b++)
            frame("R3 single", 8'd62, 8'd58, 8'd2, 8'h04, 8'(1 << b), 8'(1 << b), 3'b100, 1'b0);
        // R4 broadcast
        frame("R4 broadcast", 8'd62, 8'd58, 8'd2, 8'h14, 8'h00, 8'h00, 3'b100, 1'b0);
        frame("R4 broadcast2", 8'd62, 8'd58, 8'd2, 8'h08, 8'h00, 8'h5A, 3'b100, 1'b0);
        // R5 / R6 reserved bits
        frame("R5 bit0", 8'd62, 8'd58, 8'd2, 8'h25, 8'h01, 8'h01, 3'b100, 1'b0);
        frame("R5 bit1", 8'd62, 8'd58, 8'd2, 8'h02, 8'h01, 8'h01, 3'b100, 1'b0);
        frame("R5 bit7 nomatch", 8'd62, 8'd58, 8'd2, 8'h80, 8'h01, 8'h02, 3'b100, 1'b0);
        frame("R6 bit0 off", 8'd62, 8'd58, 8'd2, 8'h25, 8'h01, 8'h01, 3'b100, 1'b1);
        frame("R6 bit7 off", 8'd62, 8'd58, 8'd2, 8'h90, 8'h00, 8'h00, 3'b100, 1'b1);
        frame("R6 all resv off", 8'd62, 8'd58, 8'd2, 8'h83, 8'h03, 8'h01, 3'b100, 1'b1);
        // R7 each command alone
        for (int b = 2; b < 7; b++)
            frame("R7 cmd bit", 8'd62, 8'd58, 8'd2, 8'(1 << b), 8'h00, 8'h00, 3'b100, 1'b0);
        // R8 cancellation
        frame("R8 freeze pair", 8'd62, 8'd58, 8'd2, 8'h18, 8'h00, 8'h00, 3'b100, 1'b0);
        frame("R8 sync pair", 8'd62, 8'd58, 8'd2, 8'h60, 8'h00, 8'h00, 3'b100, 1'b0);
        frame("R8 both+clear", 8'd62, 8'd58, 8'd2, 8'h7C, 8'h00, 8'h00, 3'b100, 1'b0);
        frame("R8 sync+freeze", 8'd62, 8'd58, 8'd2, 8'h30, 8'h00, 8'h00, 3'b100, 1'b0);

        // R9 one-cycle pulse and back-to-back strobes
        @(negedge clk);
        drive(8'd62, 8'd58, 8'd2, 8'h20, 8'h00, 8'h00, 3'b100, 1'b0);
        @(negedge clk);
        check("R9 first of pair", model(8'd62, 8'd58, 8'd2, 8'h20, 8'h00, 8'h00, 3'b100, 1'b0));
        drive(8'd62, 8'd58, 8'd2, 8'h80, 8'h00, 8'h00, 3'b100, 1'b0);
        @(negedge clk);
        frm_valid = 1'b0;
        check("R9 second of pair", 7'b1000000);
        @(negedge clk);
        check("R9 pulse ends", 7'b0);
        @(negedge clk);
        drive(8'd62, 8'd58, 8'd2, 8'h10, 8'h00, 8'h00, 3'b100, 1'b0);
        check("R9 no early output", 7'b0);
        @(negedge clk);
        frm_valid = 1'b0;
        check("R9 one clock later", 7'b0100000 | 7'b0001000);
        repeat (3) begin
            @(negedge clk);
            check("R10 quiet", 7'b0);
        end

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] ss, ds, ln, gs, gi;
            logic [2:0] st;
            ss = ($urandom % 4 != 0) ? 8'd62 : 8'($urandom);
            ds = ($urandom % 4 != 0) ? 8'd58 : 8'($urandom);
            ln = ($urandom % 4 != 0) ? 8'd2  : 8'($urandom % 4);
            st = ($urandom % 4 != 0) ? 3'b100 : 3'($urandom);
            cm = 8'($urandom);
            if ($urandom % 2 == 0) cm = cm & 8'h7C;
            gs = ($urandom % 5 == 0) ? 8'h00 : 8'($urandom);
            gi = 8'($urandom);
            frame("R3 R5 R7 R8 random", ss, ds, ln, cm, gs, gi, st, 1'($urandom));
        end

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule